// File: doc/BRIEF.md
# Clipped Signed Amplitude Scaler

This block multiplies a stream of signed samples, such as the output of a sine generator, by a signed scale factor. It returns a product one bit narrower than the full product width, and no information is lost. The full product of an M-bit and an N-bit two's-complement value needs M+N bits for only one operand pair: both operands at their most negative code. Everywhere else the two top bits of the product are equal, so the upper one only repeats the sign.

The scaler keeps that pair out of the multiplier. It clips the scale factor before the multiply: a scale factor at its most negative code is replaced by that code plus one. The low M+N-1 product bits are then exact, and a full-scale scale factor of either sign gives near full-scale output, with no loss of half the amplitude. A coefficient source that can never produce the most negative code can select a pass-through mode that skips the clip.

Samples are qualified by a valid strobe. Results leave two cycles later on a valid-qualified output, together with a truncated copy that keeps only the top bits.

Top module: `amp_scaler`

## Requirements
- R1: When `out_valid` is high, `out_full` equals the signed product of the sample and the effective scale factor, taken in its low M+N-1 bits. A zero sample gives a zero result.
- R2: In clip mode (`CLIP_MODE` = COEF_CLIP), a scale factor equal to the most negative N-bit code (sign bit 1, all other bits 0) is used as that code plus one. Every other code is used unchanged.
- R3: In clip mode, bits M+N-1 and M+N-2 of the internal full-width product are always equal. Read as a signed M+N-1-bit number, `out_full` therefore equals the exact product for every pair of input codes.
- R4: `out_valid` goes high exactly two clock cycles after a cycle in which `in_valid` is sampled high, and is low two cycles after `in_valid` is sampled low. Back-to-back samples give back-to-back results.
- R5: While no new valid sample reaches the output stage, `out_full` and `out_trunc` hold the last result.
- R6: `out_trunc` equals the top K bits of `out_full`, that is bits M+N-2 down to M+N-1-K.
- R7: A synchronous active-high `rst` clears `out_valid`, `out_full` and `out_trunc` to zero at the next clock edge, and also drops any sample still in the pipeline.
- R8: In pass-through mode (`CLIP_MODE` = COEF_PASS), the scale factor reaches the multiplier unchanged, so a sample of 1 times the most negative scale factor gives the most negative scale factor as the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SMP_W | Signed sample |
| in_coef | input | COEF_W | Signed scale factor, sampled together with the sample |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_full | output | SMP_W+COEF_W-1 | Signed product, redundant sign bit removed |
| out_trunc | output | TRUNC_W | Top TRUNC_W bits of `out_full` |

## Verification
Every result is due on the second rising edge after the edge that samples `in_valid`. The bench drives inputs at falling edges. It checks the result of the sample driven at falling edge n at falling edge n+2, so a stream of one vector per cycle is checked with exactly two vectors in flight. After the stream stops, `out_valid` must be low at the next falling edge while the data holds its last value. Reset is checked at the falling edge after the first reset edge.

// File: rtl/amp_scaler_pkg.sv
package amp_scaler_pkg;
    typedef enum logic [0:0] {
        COEF_CLIP = 1'b0,
        COEF_PASS = 1'b1
    } coef_mode_e;
endpackage

// File: rtl/coef_clip.sv
module coef_clip
    import amp_scaler_pkg::*;
#(
    parameter int         COEF_W = 12,
    parameter coef_mode_e MODE   = COEF_CLIP
) (
    input  logic [COEF_W-1:0] coef_i,
    output logic [COEF_W-1:0] coef_o
);
    localparam logic [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};
    localparam logic [COEF_W-1:0] NEG_SAFE = MOST_NEG | {{(COEF_W-1){1'b0}}, 1'b1};

    generate
        if (MODE == COEF_CLIP) begin : g_clip
            always_comb begin
                coef_o = (coef_i == MOST_NEG) ? NEG_SAFE : coef_i;
            end
        end else begin : g_pass
            always_comb begin
                coef_o = coef_i;
            end
        end
    endgenerate
endmodule

// File: rtl/scale_mult.sv
module scale_mult
    import amp_scaler_pkg::*;
#(
    parameter int         SMP_W  = 16,
    parameter int         COEF_W = 12,
    parameter coef_mode_e MODE   = COEF_CLIP
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic [SMP_W-1:0]        smp_i,
    input  logic [COEF_W-1:0]       coef_i,
    output logic                    vld_o,
    output logic [SMP_W+COEF_W-1:0] prod_o
);
    localparam int                PW       = SMP_W + COEF_W;
    localparam logic [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};

    typedef struct packed {
        logic              v1;
        logic [SMP_W-1:0]  s;
        logic [COEF_W-1:0] c;
        logic              v2;
        logic [PW-1:0]     p;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.v1 = vld_i;
        st_d.v2 = st_q.v1;
        if (vld_i) begin
            st_d.s = smp_i;
            st_d.c = coef_i;
        end
        if (st_q.v1) begin
            st_d.p = PW'($signed(st_q.s)) * PW'($signed(st_q.c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.v2;
    assign prod_o = st_q.p;

    generate
        if (MODE == COEF_CLIP) begin : g_chk
            // R2
            clip_reach_chk: assert property (@(posedge clk) disable iff (rst)
                st_q.v1 |-> st_q.c != MOST_NEG);
            // R3
            sign_dup_chk: assert property (@(posedge clk) disable iff (rst)
                st_q.v1 |=> st_q.p[PW-1] == st_q.p[PW-2]);
        end
    endgenerate
endmodule

// File: rtl/amp_scaler.sv
module amp_scaler
    import amp_scaler_pkg::*;
#(
    parameter int         SMP_W     = 16,
    parameter int         COEF_W    = 12,
    parameter int         TRUNC_W   = 16,
    parameter coef_mode_e CLIP_MODE = COEF_CLIP
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [SMP_W-1:0]          in_sample,
    input  logic [COEF_W-1:0]         in_coef,
    output logic                      out_valid,
    output logic [SMP_W+COEF_W-2:0]   out_full,
    output logic [TRUNC_W-1:0]        out_trunc
);
    localparam int PW    = SMP_W + COEF_W;
    localparam int OUT_W = PW - 1;

    logic [COEF_W-1:0] coef_eff;
    logic [PW-1:0]     prod;

    coef_clip #(.COEF_W(COEF_W), .MODE(CLIP_MODE)) u_clip (
        .coef_i (in_coef),
        .coef_o (coef_eff)
    );

    scale_mult #(.SMP_W(SMP_W), .COEF_W(COEF_W), .MODE(CLIP_MODE)) u_mult (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .smp_i  (in_sample),
        .coef_i (coef_eff),
        .vld_o  (out_valid),
        .prod_o (prod)
    );

    assign out_full  = prod[OUT_W-1:0];
    assign out_trunc = out_full[OUT_W-1 -: TRUNC_W];

    // R4
    lat_on_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    // R4
    lat_off_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);
    // R1
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample == '0) |-> ##2 (out_full == '0));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_full));
    // R7
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_full == '0));
endmodule

// File: tb/amp_scaler_tb_top.sv
module amp_scaler_tb_top;
    import amp_scaler_pkg::*;

    localparam int SW = 16;
    localparam int CW = 12;
    localparam int KW = 16;
    localparam int OW = SW + CW - 1;
    localparam int NV = 18;

    typedef struct packed {
        logic [SW-1:0] s;
        logic [CW-1:0] c;
        logic [31:0]   e;
    } vec_t;

    // expected = sample * clipped coefficient
    localparam vec_t TBL [NV] = '{
        '{16'h8000, 12'h800,  32'd67076096},
        '{16'h8000, 12'h801,  32'd67076096},
        '{16'h8000, 12'h000,  32'd0},
        '{16'h8000, 12'h7FF, -32'sd67076096},
        '{16'h8001, 12'h800,  32'd67074049},
        '{16'h8001, 12'h801,  32'd67074049},
        '{16'h8001, 12'h000,  32'd0},
        '{16'h8001, 12'h7FF, -32'sd67074049},
        '{16'h0000, 12'h800,  32'd0},
        '{16'h0000, 12'h801,  32'd0},
        '{16'h0000, 12'h000,  32'd0},
        '{16'h0000, 12'h7FF,  32'd0},
        '{16'h7FFF, 12'h800, -32'sd67074049},
        '{16'h7FFF, 12'h801, -32'sd67074049},
        '{16'h7FFF, 12'h000,  32'd0},
        '{16'h7FFF, 12'h7FF,  32'd67074049},
        '{16'd1234, 12'hFFB, -32'sd6170},
        '{16'hFF9C, 12'd77,  -32'sd7700}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [CW-1:0] in_coef = '0;
    logic          ov_c, ov_p;
    logic [OW-1:0] of_c, of_p;
    logic [KW-1:0] ot_c, ot_p;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    amp_scaler #(.SMP_W(SW), .COEF_W(CW), .TRUNC_W(KW), .CLIP_MODE(COEF_CLIP)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_coef(in_coef), .out_valid(ov_c), .out_full(of_c), .out_trunc(ot_c));

    amp_scaler #(.SMP_W(SW), .COEF_W(CW), .TRUNC_W(KW), .CLIP_MODE(COEF_PASS)) dut_pass (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_coef(in_coef), .out_valid(ov_p), .out_full(of_p), .out_trunc(ot_p));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sx_out(input logic [OW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check_vec(input int i);
        longint e, ep;
        e  = longint'($signed(TBL[i].e));
        ep = longint'($signed(TBL[i].s)) * longint'($signed(TBL[i].c));
        chk(ov_c == 1'b1, "R4 valid after two cycles", ov_c, 1);
        chk(of_c == OW'(e), "R1 low product bits", of_c, OW'(e));
        chk(sx_out(of_c) == e, "R3 signed result equals full product", sx_out(of_c), e);
        chk(ot_c == KW'(e >>> (OW - KW)), "R6 truncated top bits", ot_c, KW'(e >>> (OW - KW)));
        if (!(TBL[i].s == 16'h8000 && TBL[i].c == 12'h800))
            chk(sx_out(of_p) == ep, "R8 pass-through product", sx_out(of_p), ep);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(ov_c == 1'b0, "R7 reset valid", ov_c, 0);
        chk(of_c == '0, "R7 reset data", of_c, 0);
        chk(ot_c == '0, "R7 reset trunc", ot_c, 0);
        rst = 1'b0;

        // table walk, one vector per cycle, checked two cycles later
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_vec(i - 2);
            if (i < NV) begin
                in_valid  = 1'b1;
                in_sample = TBL[i].s;
                in_coef   = TBL[i].c;
            end else begin
                in_valid = 1'b0;
            end
        end
        // R4 off, R5 hold
        @(negedge clk);
        chk(ov_c == 1'b0, "R4 valid drops", ov_c, 0);
        chk(sx_out(of_c) == -7700, "R5 hold full", sx_out(of_c), -7700);
        in_sample = 16'h7FFF;
        in_coef   = 12'h7FF;
        repeat (3) @(negedge clk);
        chk(sx_out(of_c) == -7700, "R5 hold with idle inputs", sx_out(of_c), -7700);
        chk(ot_c == KW'(-7700 >>> (OW - KW)), "R5 hold trunc", ot_c, KW'(-7700 >>> (OW - KW)));

        // R2 most negative coefficient seen as most negative plus one
        in_valid  = 1'b1;
        in_sample = 16'd1;
        in_coef   = 12'h800;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(sx_out(of_c) == -2047, "R2 clipped coefficient", sx_out(of_c), -2047);
        chk(sx_out(of_p) == -2048, "R8 unclipped coefficient", sx_out(of_p), -2048);

        // R7 reset with a sample in flight
        in_valid  = 1'b1;
        in_sample = 16'd100;
        in_coef   = 12'd100;
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(ov_c == 1'b0, "R7 mid-stream valid", ov_c, 0);
        chk(of_c == '0, "R7 mid-stream data", of_c, 0);
        @(negedge clk);
        chk(ov_c == 1'b0, "R7 flushed sample", ov_c, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule